// File: doc/BRIEF.md
# Password-Armed Pin Lock Guard

This block protects up to eight banks of 32 general-purpose pins from accidental reconfiguration. Each bank has a lock word with one bit per pin: a 1 means the pin is locked and its configuration and output registers must refuse writes, a 0 means the pin is free. The lock words go straight to the downstream pin logic as one flat vector. Software can read them back over the register bus, so a single pin can be changed by read-modify-write.

A lock word can only be changed right after a write of a fixed password to a global password register. A correct password arms a one-shot permit, and the very next bus write of any kind uses it up. A lock write that finds the block disarmed is dropped and raises a sticky violation flag. A password write with any other value disarms the block. Reset leaves every pin locked and the block disarmed.

Control is a two-state machine. In DISARMED, a correct password write takes the transition ARM to ARMED. Every other write stays in DISARMED, and a lock write there takes the self-loop REJECT, which sets the violation flag. In ARMED, a correct password write takes REARM and stays in ARMED. A wrong password write takes ABORT back to DISARMED. A lock write takes COMMIT back to DISARMED and updates the addressed word. Any other write takes CONSUME back to DISARMED. Reads never move the state.

Top module: `pin_lock_guard`

## Requirements
- R1: After reset every bit of every lock word is 1, the block is disarmed and the violation flag is 0.
- R2: A write of 0x00A5A501 to the password register at byte address 0x520 arms the block, from either state.
- R3: A write to the word-aligned lock register of bank b, at byte address 0x500 + 4*b with b below the bank count, made while armed, loads the write data into that bank's lock word. The new value appears on the lock vector bits [32*b+31 : 32*b] and on readback one cycle later.
- R4: The permit is one-shot. After a lock write has used it, a second lock write is ignored.
- R5: A lock write made while disarmed leaves every lock word unchanged and sets the violation flag.
- R6: A password write with any value other than 0x00A5A501 disarms the block.
- R7: A write to any other address, including a misaligned address inside the lock range, uses up the permit without changing a lock word or the violation flag.
- R8: A bus read never consumes the permit and never changes the stored state.
- R9: A read of an aligned lock register returns that bank's lock word in the same cycle. A read of any other address returns 0.
- R10: Once set, the violation flag stays set until reset.
- R11: A lock write changes only the addressed bank. All other banks keep their words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_rd is high, else 0 |
| lock_vec | output | 256 | All lock words, bank b at bits [32*b+31 : 32*b] |
| violation | output | 1 | Sticky flag for a lock write refused while disarmed |

## Verification
The armed state cannot be seen at the ports. It only shows in the outcome of the next lock write, so every arming path has to be followed by a probing lock write. The bench tracks the permit in its own model. Random operation mixes place correct and wrong passwords, unrelated and misaligned writes, and reads between arming and the probe, which covers every transition. Directed sequences pin down the one-shot rule and the fact that reads leave the permit alone.

// File: rtl/pl_pkg.sv
package pl_pkg;
    localparam logic [31:0] PL_PASSWORD = 32'h00A5_A501;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_t;
endpackage

// File: rtl/pl_decode.sv
module pl_decode #(
    parameter int ADDR_W    = 12,
    parameter int NBANK     = 8,
    parameter int LOCK_BASE = 'h500,
    parameter int PASS_ADDR = 'h520,
    localparam int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              pass_hit,
    output logic              lock_hit,
    output logic [BANK_W-1:0] bank_idx
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] word_idx;

    always_comb begin
        offset   = addr - ADDR_W'(LOCK_BASE);
        word_idx = offset >> 2;
        pass_hit = (addr == ADDR_W'(PASS_ADDR));
        lock_hit = (addr >= ADDR_W'(LOCK_BASE))
                && (offset < ADDR_W'(4 * NBANK))
                && (offset[1:0] == 2'b00);
        bank_idx = word_idx[BANK_W-1:0];
    end
endmodule

// File: rtl/pl_arm_fsm.sv
module pl_arm_fsm
    import pl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        pass_hit,
    input  logic        lock_hit,
    input  logic [31:0] wdata,
    output logic        lock_we,
    output logic        armed,
    output logic        violation
);
    arm_state_t state_q, state_d;
    logic       viol_q;
    logic       pass_ok;
    logic       reject;

    assign pass_ok = bus_wr && pass_hit && (wdata == PL_PASSWORD);

    // next state: every write leaves ARMED unless it is a correct password
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (pass_ok) state_d = ST_ARMED;        // ARM
            ST_ARMED:    if (bus_wr && !pass_ok) state_d = ST_DISARMED; // COMMIT/CONSUME/ABORT
            default:     state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    // outputs of the current state
    always_comb begin
        lock_we = 1'b0;
        reject  = 1'b0;
        unique case (state_q)
            ST_DISARMED: reject  = bus_wr && lock_hit;           // REJECT
            ST_ARMED:    lock_we = bus_wr && lock_hit;           // COMMIT
            default:     reject  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      viol_q <= 1'b0;
        else if (reject) viol_q <= 1'b1;
    end

    assign armed     = (state_q == ST_ARMED);
    assign violation = viol_q;
endmodule

// File: rtl/pl_lock_store.sv
module pl_lock_store #(
    parameter int NBANK   = 8,
    parameter int WORD_W  = 32,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [BANK_W-1:0]       bank_idx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [NBANK*WORD_W-1:0] words
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (we && (bank_idx == BANK_W'(b)))
                word_q <= wdata;
        end
        assign words[b*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/pin_lock_guard.sv
module pin_lock_guard #(
    parameter int ADDR_W    = 12,
    parameter int NBANK     = 8,
    parameter int WORD_W    = 32,
    parameter int LOCK_BASE = 'h500,
    parameter int PASS_ADDR = 'h520,
    localparam int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [NBANK*WORD_W-1:0] lock_vec,
    output logic                    violation
);
    logic              pass_hit;
    logic              lock_hit;
    logic [BANK_W-1:0] bank_idx;
    logic              lock_we;
    logic              armed;

    pl_decode #(
        .ADDR_W(ADDR_W), .NBANK(NBANK),
        .LOCK_BASE(LOCK_BASE), .PASS_ADDR(PASS_ADDR)
    ) u_decode (
        .addr(bus_addr), .pass_hit(pass_hit),
        .lock_hit(lock_hit), .bank_idx(bank_idx)
    );

    pl_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .pass_hit(pass_hit), .lock_hit(lock_hit),
        .wdata(32'(bus_wdata)), .lock_we(lock_we),
        .armed(armed), .violation(violation)
    );

    pl_lock_store #(.NBANK(NBANK), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(lock_we),
        .bank_idx(bank_idx), .wdata(bus_wdata), .words(lock_vec)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && lock_hit)
            bus_rdata = lock_vec[bank_idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/pin_lock_guard_chk.sv
module pin_lock_guard_chk #(
    parameter int ADDR_W    = 12,
    parameter int NBANK     = 8,
    parameter int WORD_W    = 32,
    parameter int LOCK_BASE = 'h500,
    parameter int PASS_ADDR = 'h520
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [WORD_W-1:0]       bus_wdata,
    input logic [NBANK*WORD_W-1:0] lock_vec,
    input logic                    violation,
    input logic                    armed
);
    logic in_lock;
    logic good_pass;
    assign in_lock = (int'(bus_addr) >= LOCK_BASE)
                  && (int'(bus_addr) < LOCK_BASE + 4 * NBANK)
                  && (bus_addr[1:0] == 2'b00);
    assign good_pass = bus_wr && (int'(bus_addr) == PASS_ADDR)
                    && (32'(bus_wdata) == 32'h00A5_A501);

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        good_pass |=> armed);
    assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !good_pass) |=> !armed);
    assert_no_update_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && bus_wr && in_lock) |=> $stable(lock_vec));
    assert_flag_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && bus_wr && in_lock) |=> violation);
    assert_change_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_vec) |-> $past(armed && bus_wr && in_lock));
    assert_read_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(lock_vec) && $stable(armed)));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
endmodule

bind pin_lock_guard pin_lock_guard_chk #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .WORD_W(WORD_W),
    .LOCK_BASE(LOCK_BASE), .PASS_ADDR(PASS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lock_vec(lock_vec), .violation(violation),
    .armed(armed)
);

// File: tb/pin_lock_guard_bench.sv
module pin_lock_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam logic [31:0] PASS = 32'h00A5_A501;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [255:0]  lock_vec;
    logic          violation;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_lock [NB];
    logic        m_armed;
    logic        m_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_lock_guard u_pin_lock_guard (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_vec(lock_vec), .violation(violation)
    );

    function automatic logic [255:0] exp_vec();
        logic [255:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_lock[b];
        return v;
    endfunction

    function automatic logic is_lock(input logic [11:0] a);
        return (a >= 12'h500) && (a < 12'h520) && (a[1:0] == 2'b00);
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (is_lock(a)) begin
            if (m_armed) m_lock[(a - 12'h500) >> 2] = d;
            else         m_viol = 1'b1;
        end
        m_armed = (a == 12'h520) && (d == PASS);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        check(req, lock_vec, exp_vec());
        check(req, 256'(violation), 256'(m_viol));
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        e = is_lock(a) ? m_lock[(a - 12'h500) >> 2] : 32'h0;
        check(req, 256'(bus_rdata), 256'(e));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) m_lock[b] = '1;
        m_armed = 1'b0; m_viol = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", lock_vec, {256{1'b1}});
        check("R1", 256'(violation), 256'(0));
        // R2 / R3 arm and unlock bank 2
        wr(12'h520, PASS, "R2");
        wr(12'h508, 32'h0000_F00F, "R3");
        rd(12'h508, "R9");
        // R11 other banks untouched
        check("R11", 256'(lock_vec[31:0]), 256'(32'hFFFF_FFFF));
        // R4 second write ignored
        wr(12'h508, 32'h0, "R4");
        check("R4", 256'(lock_vec[95:64]), 256'(32'h0000_F00F));
        // R10 sticky
        wr(12'h100, 32'h1, "R10");
        // R6 wrong password disarms
        wr(12'h520, PASS, "R6");
        wr(12'h520, 32'h00A5_A500, "R6");
        wr(12'h51C, 32'h0, "R6");
        // R7 unrelated and misaligned writes consume permit
        wr(12'h520, PASS, "R7");
        wr(12'h502, 32'h0, "R7");
        wr(12'h500, 32'h0, "R7");
        // R8 reads keep the permit
        wr(12'h520, PASS, "R8");
        rd(12'h500, "R8");
        rd(12'h520, "R9");
        wr(12'h51C, 32'h1234_5678, "R8");
        check("R8", 256'(lock_vec[255:224]), 256'(32'h1234_5678));
        // R2 rearm from armed
        wr(12'h520, PASS, "R2");
        wr(12'h520, PASS, "R2");
        wr(12'h504, 32'hA5A5_0000, "R2");
        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 6);
            a  = 12'h500 + 12'(4 * ($urandom % NB));
            case (op)
                0, 1: wr(12'h520, PASS, "R2");
                2:    wr(12'h520, $urandom, "R6");
                3:    wr(a, $urandom, "R3");
                4:    wr(12'($urandom), $urandom, "R7");
                default: rd(($urandom % 2) ? a : 12'($urandom), "R9");
            endcase
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule